// File: doc/BRIEF.md
# Synchronising SCL Bit-Rate Generator

This block produces the serial clock of a two-wire bus master from the system clock. Each half of the SCL period lasts `8 + bit_rate * 4^prescale` system clocks, which gives a full period of `16 + 2 * bit_rate * 4^prescale` clocks. The generator only ever pulls the line low or lets it go. The low and high counts restart from the bus line as observed through a synchroniser, not from its own drive. As a result, several masters on the same wired-AND line settle into one combined clock, and a device that holds the line low simply lengthens the low phase.

A bit engine uses two single-cycle strobes. `sda_chg` marks the point in each low phase where SDA may be changed. `sda_smp` marks the middle of each high phase, where SDA is sampled. While `run` is low the generator releases the line, ignores it, and emits no strobes. When `run` rises, the next clock pulls SCL low to start the first period. For correct master operation the bit-rate value should be 10 or more. Smaller values are accepted, but they leave too few clocks around the START and address bits.

Top module: `scl_rate_gen`

## Requirements
- R1: While `rst` is high, `scl_oe` is 0 and both strobes are 0, whatever `run` is.
- R2: With an unobstructed line, `scl_oe` stays 1 for exactly H = 8 + bit_rate * 4^prescale clocks per low phase (`prescale` codes 0..3 select 1, 4, 16, 64).
- R3: With an unobstructed line, the high phase lasts exactly H clocks, so the full period is 2H.
- R4: If the line is still low when the low count ends, `scl_oe` stays 0 for as long as the line stays low. The next low phase begins exactly H clocks after the line actually rises.
- R5: If the line falls during the high phase because another device pulls it, the generator takes over the low drive and releases exactly H clocks after that fall. When the observed fall and the end of its own high count land in the same clock, the observed fall sets the timing.
- R6: `sda_chg` pulses once per low phase, CHG_DLY (default 4) clocks after the line falls, and only while `scl_oe` is 1.
- R7: `sda_smp` pulses once per high phase, floor(H/2) clocks after the line rises, and only while `scl_oe` is 0.
- R8: One clock after `run` is sampled low, `scl_oe` is 0. Activity on `scl_in` then produces no strobe and no drive.
- R9: When `run` is sampled high while idle, `scl_oe` becomes 1 in the next clock and the first low phase starts there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables clock generation; low releases SCL |
| bit_rate | input | BR_W | Bit-rate value (8 bits by default) |
| prescale | input | 2 | Prescaler code; multiplies the bit-rate by 4^code |
| scl_in | input | 1 | Observed level of the wired-AND SCL line (asynchronous) |
| scl_oe | output | 1 | 1 pulls SCL low; 0 releases it |
| sda_chg | output | 1 | Single-cycle strobe: SDA may change |
| sda_smp | output | 1 | Single-cycle strobe: sample SDA |

## Verification
Two events can fall in the same clock: the end of the generator's own high count, and the synchronised observation that another device has already pulled the line low. The bench provokes this by pulling the line exactly SYNC+1 clocks before the high count would end, so both causes arrive at the state machine together. It judges the outcome by the release point, which must come H clocks after the external fall rather than H clocks after the own expiry. An earlier pull in the middle of the high phase and a long stretch of the low phase are driven as separate cases, and random bit-rate and prescaler pairs are checked against the period formula.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    // Phase of the generated clock
    typedef enum logic [1:0] {
        PH_IDLE      = 2'd0,
        PH_LOW       = 2'd1,
        PH_RISE_WAIT = 2'd2,
        PH_HIGH      = 2'd3
    } scl_phase_e;

    // Strobes handed to the bit engine
    typedef struct packed {
        logic chg;
        logic smp;
    } scl_strobe_t;

    // Clocks per half period: 8 + rate * 4^code
    function automatic int unsigned half_clocks(int unsigned rate, logic [1:0] code);
        return 32'd8 + (rate << (2 * code));
    endfunction

endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_s
);
    generate
        if (STAGES <= 1) begin : g_single
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b1;
                else     q <= line_in;
            end
            assign line_s = q;
        end else begin : g_chain
            logic [STAGES-1:0] sr;
            always_ff @(posedge clk) begin
                if (rst) sr <= '1;
                else     sr <= {sr[STAGES-2:0], line_in};
            end
            assign line_s = sr[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int CW   = 15,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          line_s,
    input  logic [CW-1:0] half,
    output scl_phase_e    phase,
    output logic [CW-1:0] cnt,
    output logic          drive_low
);
    // Clocks already elapsed since a bus edge when it is first seen
    localparam logic [CW-1:0] SEEN = CW'(SYNC + 1);

    logic end_of_half;
    assign end_of_half = (cnt >= half - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            drive_low <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    phase     <= PH_LOW;
                    cnt       <= '0;
                    drive_low <= 1'b1;
                end
                PH_LOW: begin
                    if (end_of_half) begin
                        phase     <= PH_RISE_WAIT;
                        cnt       <= '0;
                        drive_low <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_RISE_WAIT: begin
                    if (line_s) begin
                        phase <= PH_HIGH;
                        cnt   <= SEEN;
                    end
                end
                PH_HIGH: begin
                    if (!line_s) begin
                        // another device pulled low first: count from its edge
                        phase     <= PH_LOW;
                        cnt       <= SEEN;
                        drive_low <= 1'b1;
                    end else if (end_of_half) begin
                        phase     <= PH_LOW;
                        cnt       <= '0;
                        drive_low <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    phase     <= PH_IDLE;
                    cnt       <= '0;
                    drive_low <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/scl_strobe_gen.sv
module scl_strobe_gen
    import scl_gen_pkg::*;
#(
    parameter int CW      = 15,
    parameter int CHG_DLY = 4
) (
    input  scl_phase_e    phase,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] half,
    output scl_strobe_t   stb
);
    localparam logic [CW-1:0] CHG_AT = CW'(CHG_DLY);

    always_comb begin
        stb.chg = (phase == PH_LOW)  && (cnt == CHG_AT);
        stb.smp = (phase == PH_HIGH) && (cnt == (half >> 1));
    end
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
    import scl_gen_pkg::*;
#(
    parameter int BR_W        = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CHG_DLY     = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [BR_W-1:0] bit_rate,
    input  logic [1:0]      prescale,
    input  logic            scl_in,
    output logic            scl_oe,
    output logic            sda_chg,
    output logic            sda_smp
);
    // 8 + (2^BR_W - 1) * 64 fits in BR_W + 7 bits
    localparam int CW = BR_W + 7;

    logic          line_s;
    logic [CW-1:0] half;
    logic [CW-1:0] cnt;
    scl_phase_e    phase;
    scl_strobe_t   stb;

    assign half = CW'(half_clocks(32'(bit_rate), prescale));

    scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .line_in (scl_in),
        .line_s  (line_s)
    );

    scl_phase_fsm #(.CW(CW), .SYNC(SYNC_STAGES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .line_s    (line_s),
        .half      (half),
        .phase     (phase),
        .cnt       (cnt),
        .drive_low (scl_oe)
    );

    scl_strobe_gen #(.CW(CW), .CHG_DLY(CHG_DLY)) u_stb (
        .phase (phase),
        .cnt   (cnt),
        .half  (half),
        .stb   (stb)
    );

    assign sda_chg = stb.chg;
    assign sda_smp = stb.smp;
endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk (
    input logic clk,
    input logic rst,
    input logic run,
    input logic scl_oe,
    input logic sda_chg,
    input logic sda_smp
);
    // R2: a count-driven low phase never ends in fewer than 8 clocks
    p_min_low_r2: assert property (@(posedge clk) disable iff (rst)
        ($fell(scl_oe) && $past(run)) |-> $past(scl_oe, 8));

    // R6: change strobe only while driving low
    p_chg_drive_r6: assert property (@(posedge clk) disable iff (rst)
        sda_chg |-> scl_oe);

    // R7: sample strobe only while released
    p_smp_release_r7: assert property (@(posedge clk) disable iff (rst)
        sda_smp |-> !scl_oe);

    // R8: stopping releases the line and silences the strobes
    p_idle_release_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!scl_oe && !sda_chg && !sda_smp));
endmodule

bind scl_rate_gen scl_rate_gen_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .scl_oe  (scl_oe),
    .sda_chg (sda_chg),
    .sda_smp (sda_smp)
);

// File: tb/sim_scl_rate_gen.sv
module sim_scl_rate_gen;
    localparam int CLK_NS  = 10;
    localparam int CHG     = 4;
    localparam int SYNC    = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic [7:0] br  = 8'd10;
    logic [1:0] ps  = 2'd0;
    logic       ext_low = 1'b0;
    logic       scl_oe, sda_chg, sda_smp;
    wire        scl_line = !(scl_oe || ext_low);

    int cyc = 0;
    int n_checks = 0, n_err = 0;
    int n_chg = 0, n_smp = 0, last_chg = 0, last_smp = 0;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    scl_rate_gen u0 (
        .clk(clk), .rst(rst), .run(run), .bit_rate(br), .prescale(ps),
        .scl_in(scl_line), .scl_oe(scl_oe), .sda_chg(sda_chg), .sda_smp(sda_smp)
    );

    always @(negedge clk) begin
        if (sda_chg) begin n_chg++; last_chg = cyc; end
        if (sda_smp) begin n_smp++; last_smp = cyc; end
    end

    function automatic int exp_half(int b, int p);
        return 8 + b * (1 << (2 * p));
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_oe(logic v, output int t);
        do @(negedge clk); while (scl_oe !== v);
        t = cyc;
    endtask

    task automatic start(int b, int p, output int t0);
        int a;
        @(negedge clk); run = 1'b0;
        repeat (3) @(negedge clk);
        br = 8'(b); ps = 2'(p);
        @(negedge clk); run = 1'b1; a = cyc;
        wait_oe(1'b1, t0);
        chk("R9 start latency", t0 - a, 1);
    endtask

    task automatic run_periods(int t_start, int nper);
        int h, t0, t1, t2, c0, s0;
        h = exp_half(br, ps);
        t0 = t_start;
        repeat (nper) begin
            c0 = n_chg; s0 = n_smp;
            wait_oe(1'b0, t1);
            wait_oe(1'b1, t2);
            chk($sformatf("R2 low br=%0d ps=%0d", br, ps), t1 - t0, h);
            chk($sformatf("R3 high br=%0d ps=%0d", br, ps), t2 - t1, h);
            chk("R6 chg count", n_chg - c0, 1);
            chk("R6 chg position", last_chg - t0, CHG);
            chk("R7 smp count", n_smp - s0, 1);
            chk("R7 smp position", last_smp - t1, h / 2);
            t0 = t2;
        end
    endtask

    initial begin
        int t, r, s, m, f, h, c0, s0, bad, seed;
        // R1: reset dominates run
        run = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 oe in reset", scl_oe, 0);
        chk("R1 strobes in reset", sda_chg | sda_smp, 0);
        run = 1'b0;
        @(negedge clk); rst = 1'b0;

        // directed formula corners
        start(10, 0, t);  run_periods(t, 3);
        start(200, 0, t); run_periods(t, 2);
        start(15, 3, t);  run_periods(t, 2);
        start(33, 1, t);  run_periods(t, 2);

        // random pairs
        seed = $urandom(32'd7321);
        for (int i = 0; i < 6; i++) begin
            start(10 + int'($urandom_range(20)), int'($urandom_range(3)), t);
            run_periods(t, 2);
        end

        // R4: stretched low phase
        start(10, 1, t); h = exp_half(10, 1);
        ext_low = 1'b1;
        wait_oe(1'b0, r);
        repeat (20) @(negedge clk);
        chk("R4 released while held", scl_oe, 0);
        s0 = n_smp;
        ext_low = 1'b0; s = cyc;
        wait_oe(1'b1, t);
        chk("R4 high from real rise", t - s, h);
        chk("R7 smp count stretched", n_smp - s0, 1);
        chk("R7 smp after stretch", last_smp - s, h / 2);

        // R5: early pull mid-high
        wait_oe(1'b0, r);
        while (cyc < r + 10) @(negedge clk);
        ext_low = 1'b1; m = cyc; c0 = n_chg;
        repeat (4) @(negedge clk);
        chk("R5 takes over drive", scl_oe, 1);
        repeat (2) @(negedge clk);
        ext_low = 1'b0;
        wait_oe(1'b0, f);
        chk("R5 release after early fall", f - m, h);
        chk("R6 chg after foreign fall", last_chg - m, CHG);
        chk("R6 chg count foreign", n_chg - c0, 1);

        // R5: foreign fall seen in the same clock as own expiry
        while (cyc < f + h - (SYNC + 1)) @(negedge clk);
        ext_low = 1'b1; m = cyc;
        repeat (6) @(negedge clk);
        ext_low = 1'b0;
        wait_oe(1'b0, f);
        chk("R5 coincident fall wins", f - m, h);

        // R8: stop and ignore the bus
        @(negedge clk); run = 1'b0;
        @(negedge clk);
        chk("R8 released after stop", scl_oe, 0);
        c0 = n_chg; s0 = n_smp; bad = 0;
        for (int k = 0; k < 200; k++) begin
            ext_low = k[3];
            @(negedge clk);
            if (scl_oe) bad++;
        end
        ext_low = 1'b0;
        chk("R8 no drive while idle", bad, 0);
        chk("R8 no strobes while idle", (n_chg - c0) + (n_smp - s0), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL R2 watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule